// File: doc/BRIEF.md
# Scalar-to-Vector Instruction Issue Controller

This block decides the fate of each decoded vector instruction that a scalar decoder presents: it is pushed into the vector instruction queue, held back, or turned into a fault. The decoder offers an instruction with a valid/ready handshake. When the block raises `dec_ready` together with `dec_valid`, the instruction is consumed in that cycle. The handshake applies back-pressure in three situations: the queue is full, a synchronous-mode memory instruction has not yet finished, or a move-from-vector result is still outstanding. A consumed instruction either enters the queue or produces exactly one fault pulse.

The checks run in a fixed priority order. First, a cleared enable bit raises the disabled fault. Next, in asynchronous memory-fault mode only, a set pending-fault bit raises the memory-management fault and clears that bit. Last comes queue space. When an instruction is pushed while the memory-fault status bit is set, the block clears that bit and asks the vector side to retry the faulting reference ahead of newer work. The block has no path to the scalar condition codes, so issued vector instructions cannot alter them.

Top module: `vec_issue_ctl`

## Requirements
- R1: After reset, with no instruction offered, every output is low and no wait is in progress.
- R2: With `dec_valid` high, no wait in progress and `st_ven` low, `flt_disabled` and `dec_ready` are high for that cycle and `q_push` stays low. This check takes priority over the pending-fault and queue-full checks.
- R3: In asynchronous mode (`async_mode`=1), with `st_ven` high and `st_pmf` high, `flt_memmgt`, `clr_pmf` and `dec_ready` are high for that cycle and `q_push` stays low, even when the queue is full.
- R4: In synchronous mode (`async_mode`=0), `st_pmf` is ignored: `flt_memmgt` and `clr_pmf` never rise, and the instruction goes on to the queue check.
- R5: When the queue check is reached and `q_full` is high, `q_push` and `dec_ready` are low and `scalar_stall` is high.
- R6: When the queue check is reached and `q_full` is low, `q_push` and `dec_ready` are high in the same cycle.
- R7: `clr_mf` and `retry_req` pulse in exactly the cycles where `q_push` is high and `st_mf` is high, and in no other cycle.
- R8: In synchronous mode, a pushed instruction with `dec_is_mem`=1 drops `dec_ready` from the next cycle on. The block accepts no instruction until the cycle after the one in which `mem_done` is high.
- R9: A pushed instruction with `dec_is_mfv`=1 holds `scalar_stall` high and `dec_ready` low from the next cycle through the cycle in which `res_valid` is high. A `res_valid` seen while no result is awaited has no effect.
- R10: At most one of `q_push`, `flt_disabled` and `flt_memmgt` is high in any cycle, and none is high without `dec_valid`. `dec_ready` is high only when one of them is.
- R11: In asynchronous mode, a pushed memory instruction causes no wait, so the next instruction may issue in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | 1 = asynchronous memory-fault handling, 0 = synchronous |
| dec_valid | input | 1 | Decoded vector instruction offered |
| dec_ready | output | 1 | Instruction consumed this cycle |
| dec_is_mem | input | 1 | Offered instruction accesses vector memory |
| dec_is_mfv | input | 1 | Offered instruction moves a value from the vector unit |
| st_ven | input | 1 | Vector enable status bit as seen by the scalar side |
| st_pmf | input | 1 | Pending memory-fault status bit |
| st_mf | input | 1 | Memory-fault status bit |
| q_full | input | 1 | Vector instruction queue has no room |
| q_push | output | 1 | Write the instruction into the queue |
| res_valid | input | 1 | Move-from-vector result written back |
| mem_done | input | 1 | Outstanding vector memory instruction completed cleanly |
| flt_disabled | output | 1 | Vector-disabled fault pulse |
| flt_memmgt | output | 1 | Memory-management fault pulse |
| clr_pmf | output | 1 | Clear the pending memory-fault bit |
| clr_mf | output | 1 | Clear the memory-fault bit |
| retry_req | output | 1 | Retry the faulting memory reference before newer queued work |
| scalar_stall | output | 1 | Hold the scalar pipeline |

## Verification
Some properties are checked on every cycle: the exclusivity and validity of push and fault pulses, the link between `retry_req` and a push with `st_mf` set, the silence of the pending-fault path in synchronous mode, and the start of both waits in the cycle after the triggering push. Other behaviour can only be shown by the bench's scenarios. These are the exact priority between simultaneous conditions, the length of each wait and its release one cycle after `res_valid` or `mem_done`, and the fact that a stray `res_valid` is ignored.

// File: rtl/vecissue_pkg.sv
package vecissue_pkg;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_HOLD   = 3'd1,
    ACT_FLTDIS = 3'd2,
    ACT_FLTMM  = 3'd3,
    ACT_FULL   = 3'd4,
    ACT_PUSH   = 3'd5
  } issue_act_e;

  typedef enum logic {
    WAIT_MEM = 1'b0,
    WAIT_MFV = 1'b1
  } wait_kind_e;

endpackage

// File: rtl/vecissue_arbiter.sv
module vecissue_arbiter
  import vecissue_pkg::*;
(
  input  logic       valid,
  input  logic       blocked,
  input  logic       ven,
  input  logic       pmf,
  input  logic       async_en,
  input  logic       full,
  output issue_act_e act
);

  // Fixed priority: outstanding wait, enable, pending fault, queue space.
  always_comb begin
    if (!valid)                act = ACT_NONE;
    else if (blocked)          act = ACT_HOLD;
    else if (!ven)             act = ACT_FLTDIS;
    else if (async_en && pmf)  act = ACT_FLTMM;
    else if (full)             act = ACT_FULL;
    else                       act = ACT_PUSH;
  end

endmodule

// File: rtl/vecissue_waiter.sv
module vecissue_waiter
  import vecissue_pkg::*;
#(
  parameter wait_kind_e KIND = WAIT_MEM
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy
);

  logic busy_q;

  // A completion only counts while a wait is open.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_q <= 1'b0;
    else if (busy_q && done) busy_q <= 1'b0;
    else if (start)          busy_q <= 1'b1;
  end

  assign busy = busy_q;

  // KIND records the purpose of the instance only.
  wait_kind_e kind_tag;
  assign kind_tag = KIND;

endmodule

// File: rtl/vec_issue_ctl.sv
module vec_issue_ctl
  import vecissue_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic dec_valid,
  output logic dec_ready,
  input  logic dec_is_mem,
  input  logic dec_is_mfv,
  input  logic st_ven,
  input  logic st_pmf,
  input  logic st_mf,
  input  logic q_full,
  output logic q_push,
  input  logic res_valid,
  input  logic mem_done,
  output logic flt_disabled,
  output logic flt_memmgt,
  output logic clr_pmf,
  output logic clr_mf,
  output logic retry_req,
  output logic scalar_stall
);

  issue_act_e act;
  logic       mem_busy;
  logic       mfv_busy;
  logic       pushed;

  vecissue_arbiter u_arb (
    .valid    (dec_valid),
    .blocked  (mem_busy | mfv_busy),
    .ven      (st_ven),
    .pmf      (st_pmf),
    .async_en (async_mode),
    .full     (q_full),
    .act      (act)
  );

  assign pushed = (act == ACT_PUSH);

  vecissue_waiter #(.KIND(WAIT_MEM)) u_memwait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pushed & dec_is_mem & ~async_mode),
    .done  (mem_done),
    .busy  (mem_busy)
  );

  vecissue_waiter #(.KIND(WAIT_MFV)) u_mfvwait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pushed & dec_is_mfv),
    .done  (res_valid),
    .busy  (mfv_busy)
  );

  always_comb begin
    q_push       = pushed;
    flt_disabled = (act == ACT_FLTDIS);
    flt_memmgt   = (act == ACT_FLTMM);
    clr_pmf      = (act == ACT_FLTMM);
    clr_mf       = pushed & st_mf;
    retry_req    = pushed & st_mf;
    dec_ready    = pushed | (act == ACT_FLTDIS) | (act == ACT_FLTMM);
    scalar_stall = mfv_busy | (dec_valid & ~dec_ready);
  end

endmodule

// File: rtl/vecissue_chk.sv
module vecissue_chk (
  input logic clk,
  input logic rst_n,
  input logic async_mode,
  input logic dec_valid,
  input logic dec_ready,
  input logic dec_is_mem,
  input logic dec_is_mfv,
  input logic st_ven,
  input logic st_mf,
  input logic q_full,
  input logic q_push,
  input logic flt_disabled,
  input logic flt_memmgt,
  input logic clr_pmf,
  input logic retry_req,
  input logic clr_mf,
  input logic scalar_stall
);

  p_dis_nopush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !st_ven) |-> !q_push);

  p_dis_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_disabled |-> (dec_ready && !st_ven));

  p_mm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_memmgt |-> (clr_pmf && async_mode && st_ven && dec_ready));

  p_sync_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !async_mode |-> (!flt_memmgt && !clr_pmf));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !q_push);

  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req || clr_mf) |-> (q_push && st_mf));

  p_memwait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && dec_is_mem && !async_mode) |=> !dec_ready);

  p_mfvwait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && dec_is_mfv) |=> (scalar_stall && !dec_ready));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_push, flt_disabled, flt_memmgt}));

  p_needvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push || flt_disabled || flt_memmgt || dec_ready) |-> dec_valid);

endmodule

bind vec_issue_ctl vecissue_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .async_mode   (async_mode),
  .dec_valid    (dec_valid),
  .dec_ready    (dec_ready),
  .dec_is_mem   (dec_is_mem),
  .dec_is_mfv   (dec_is_mfv),
  .st_ven       (st_ven),
  .st_mf        (st_mf),
  .q_full       (q_full),
  .q_push       (q_push),
  .flt_disabled (flt_disabled),
  .flt_memmgt   (flt_memmgt),
  .clr_pmf      (clr_pmf),
  .retry_req    (retry_req),
  .clr_mf       (clr_mf),
  .scalar_stall (scalar_stall)
);

// File: tb/sim_vec_issue_ctl.sv
module sim_vec_issue_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_mode = 1'b1;
  logic dec_valid = 1'b0, dec_is_mem = 1'b0, dec_is_mfv = 1'b0;
  logic st_ven = 1'b1, st_pmf = 1'b0, st_mf = 1'b0, q_full = 1'b0;
  logic res_valid = 1'b0, mem_done = 1'b0;
  logic dec_ready, q_push, flt_disabled, flt_memmgt;
  logic clr_pmf, clr_mf, retry_req, scalar_stall;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  vec_issue_ctl u0 (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_is_mem(dec_is_mem), .dec_is_mfv(dec_is_mfv),
    .st_ven(st_ven), .st_pmf(st_pmf), .st_mf(st_mf),
    .q_full(q_full), .q_push(q_push),
    .res_valid(res_valid), .mem_done(mem_done),
    .flt_disabled(flt_disabled), .flt_memmgt(flt_memmgt),
    .clr_pmf(clr_pmf), .clr_mf(clr_mf), .retry_req(retry_req),
    .scalar_stall(scalar_stall)
  );

  // Expected word: {q_push, dec_ready, scalar_stall, flt_disabled,
  //                 flt_memmgt, clr_pmf, clr_mf, retry_req}
  task automatic step(bit v, bit mem, bit mfv, bit ven, bit pmf, bit mf,
                      bit full, bit rv, bit md, bit am,
                      logic [7:0] exp, string tag);
    @(posedge clk);
    #1;
    dec_valid = v; dec_is_mem = mem; dec_is_mfv = mfv;
    st_ven = ven; st_pmf = pmf; st_mf = mf; q_full = full;
    res_valid = rv; mem_done = md; async_mode = am;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one scoreboard entry per cycle, late in the cycle.
  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        logic [7:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {q_push, dec_ready, scalar_stall, flt_disabled,
             flt_memmgt, clr_pmf, clr_mf, retry_req};
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // v mem mfv ven pmf mf full rv md am
    step(0,0,0,1,0,0,0,0,0,1, 8'b00000000, "R1 idle after reset");
    step(1,0,0,1,0,0,0,0,0,1, 8'b11000000, "R6 plain push");
    step(1,0,0,0,1,1,1,0,0,1, 8'b01010000, "R2 disabled beats pmf and full");
    step(1,0,0,1,1,0,1,0,0,1, 8'b01001100, "R3 mm fault beats full");
    step(1,0,0,1,1,0,0,0,0,0, 8'b11000000, "R4 sync ignores pmf");
    step(1,0,0,1,0,0,1,0,0,1, 8'b00100000, "R5 queue full stalls");
    step(1,0,0,1,0,1,0,0,0,1, 8'b11000011, "R7 push with mf retries");
    step(1,0,0,1,0,1,1,0,0,1, 8'b00100000, "R7 no retry without push");
    step(1,0,0,0,0,1,0,0,0,1, 8'b01010000, "R7 no retry on fault");
    // synchronous memory wait
    step(1,1,0,1,0,0,0,0,0,0, 8'b11000000, "R8 sync mem push");
    step(1,0,0,1,0,0,0,0,0,0, 8'b00100000, "R8 waiting");
    step(1,0,0,1,0,0,0,0,1,0, 8'b00100000, "R8 done cycle still held");
    step(1,0,0,1,0,0,0,0,0,0, 8'b11000000, "R8 released");
    // asynchronous memory push
    step(1,1,0,1,0,0,0,0,0,1, 8'b11000000, "R11 async mem push");
    step(1,0,0,1,0,0,0,0,0,1, 8'b11000000, "R11 next issues at once");
    // move-from-vector wait
    step(1,0,1,1,0,0,0,0,0,1, 8'b11000000, "R9 mfv push");
    step(0,0,0,1,0,0,0,0,0,1, 8'b00100000, "R9 scalar held");
    step(1,0,0,0,0,0,0,0,0,1, 8'b00100000, "R9 wait beats disabled check");
    step(0,0,0,1,0,0,0,1,0,1, 8'b00100000, "R9 result cycle held");
    step(0,0,0,1,0,0,0,0,0,1, 8'b00000000, "R9 released");
    step(1,0,0,0,0,0,0,0,0,1, 8'b01010000, "R2 after wait");
    step(0,0,0,1,0,0,0,1,0,1, 8'b00000000, "R9 stray result ignored");
    step(1,0,0,1,0,0,0,0,0,1, 8'b11000000, "R9 push after stray result");
    step(0,0,0,1,1,1,1,0,0,1, 8'b00000000, "R10 nothing without valid");
    step(0,0,0,1,0,0,0,0,0,1, 8'b00000000, "R1 idle end");
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule